// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a 4 KiB window of 32-bit system control registers sitting on a simple word-oriented read/write port. Software must present a 16-bit key to a dedicated unlock register before any ordinary setting can change. It presents a second key to a separate lock register to protect the settings again. The current protection state is visible in a read-only status word. The bank comes out of reset locked.

Every mapped offset carries an access class: read-write, read-only or write-only. An access in the wrong direction, or to an offset with no register, is answered normally but raises a one-cycle error pulse. A read still returns whatever word is stored there, or zero where nothing is stored. One control word carries a soft-reset bit. An accepted write with that bit set stores the word and emits a one-cycle system reset request.

The subset held here covers a one-bit scratch control word, three PLL control words, a PLL status word, a UART clock control word, the soft-reset control word, a boot mode word, an identification word and two write-only trigger words.

Top module: `sysctl_bank`

## Requirements
- R1: After reset the lock status word (byte offset 0x00C, bit 0) reads 1. The PLL control words at 0x100, 0x104 and 0x108 read 0x0001A008. PLL status at 0x10C reads 0x0000003F. UART clock control at 0x154 reads 0x00003F03. Boot mode at 0x25C reads 0x00000001. The identification word at 0x530 reads the ID_VALUE parameter.
- R2: A write to 0x004 whose data bits [15:0] equal 0x767B sets the lock status to 1. Any other value there leaves the lock status unchanged.
- R3: A write to 0x008 whose data bits [15:0] equal 0xDF0D clears the lock status to 0, whatever the upper data bits are. Any other value there leaves it unchanged.
- R4: While the lock status is 1, a write to a read-write or write-only register leaves its stored value unchanged and does not raise the error flag. Writes to 0x004 and 0x008 are acted on in either lock state.
- R5: 0x004, 0x008, 0x60C and 0x614 are write-only. 0x00C, 0x10C, 0x25C and 0x530 are read-only. A read of a write-only offset, a write of a read-only offset, or any access to an unmapped offset drives err_o high for exactly the cycle after the access. A correct access leaves err_o low.
- R6: A write to a read-only or unmapped offset changes no stored value.
- R7: A read of a write-only offset returns the stored word, or zero for 0x004 and 0x008, which hold nothing, and raises err_o.
- R8: Offset 0x000 stores only bit 0 of the written data, and its upper 31 bits read back as zero.
- R9: An unlocked write to 0x200 stores the word, and when data bit 0 is 1 it drives srst_o high for exactly the cycle after the write. A locked write, or one with bit 0 clear, raises no request.
- R10: rdata_o changes only in the cycle after a read strobe and otherwise holds its value. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 12 | Byte offset into the bank |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | One-cycle access error pulse |
| srst_o | output | 1 | One-cycle soft reset request |

## Verification
The bench walks a vector table that drives the keys with wrong and right values. This includes the correct unlock key with non-zero upper bits, which a design comparing all 32 bits would reject. Writes are tried in both lock states and each target is read back. A bank that ignored the lock, or flagged locked writes as errors, fails the readback or the error check. Wrong-direction accesses are probed at each class, including a read of a write-only trigger word that must still return its data. A read at a misaligned address of the UART word catches decoders that use the low bits. The soft-reset bit is written both clear, set and while locked to catch a request that fires on any write to that word.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int BANK_BYTES = 4096;
  localparam int AW         = $clog2(BANK_BYTES);
  localparam int DW         = 32;
  localparam int KEY_W      = 16;

  typedef enum logic [1:0] {ACC_NONE = 2'd0, ACC_RO = 2'd1, ACC_WO = 2'd2, ACC_RW = 2'd3} acc_e;

  // storage slots
  localparam int SL_SCRATCH = 0;
  localparam int SL_PLL0    = 1;
  localparam int SL_PLL1    = 2;
  localparam int SL_PLL2    = 3;
  localparam int SL_PLLSTA  = 4;
  localparam int SL_UARTCK  = 5;
  localparam int SL_SRST    = 6;
  localparam int SL_BOOT    = 7;
  localparam int SL_ID      = 8;
  localparam int SL_CAL     = 9;
  localparam int SL_REFR    = 10;
  localparam int NSLOT      = 11;
  localparam int SLOT_W     = $clog2(NSLOT);

  localparam logic [AW-1:0] OFF_SCRATCH = 12'h000;
  localparam logic [AW-1:0] OFF_LOCK    = 12'h004;
  localparam logic [AW-1:0] OFF_UNLOCK  = 12'h008;
  localparam logic [AW-1:0] OFF_STATUS  = 12'h00C;
  localparam logic [AW-1:0] OFF_PLL0    = 12'h100;
  localparam logic [AW-1:0] OFF_PLL1    = 12'h104;
  localparam logic [AW-1:0] OFF_PLL2    = 12'h108;
  localparam logic [AW-1:0] OFF_PLLSTA  = 12'h10C;
  localparam logic [AW-1:0] OFF_UARTCK  = 12'h154;
  localparam logic [AW-1:0] OFF_SRST    = 12'h200;
  localparam logic [AW-1:0] OFF_BOOT    = 12'h25C;
  localparam logic [AW-1:0] OFF_ID      = 12'h530;
  localparam logic [AW-1:0] OFF_CAL     = 12'h60C;
  localparam logic [AW-1:0] OFF_REFR    = 12'h614;

  typedef struct packed {
    acc_e              cls;
    logic              is_slot;
    logic              is_lock;
    logic              is_unlock;
    logic              is_sta;
    logic [SLOT_W-1:0] slot;
  } dec_t;

  function automatic logic [DW-1:0] slot_rst(int i, logic [DW-1:0] id);
    case (i)
      SL_PLL0, SL_PLL1, SL_PLL2: slot_rst = 32'h0001_A008;
      SL_PLLSTA:                 slot_rst = 32'h0000_003F;
      SL_UARTCK:                 slot_rst = 32'h0000_3F03;
      SL_BOOT:                   slot_rst = 32'h0000_0001;
      SL_ID:                     slot_rst = id;
      default:                   slot_rst = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] slot_mask(int i);
    slot_mask = (i == SL_SCRATCH) ? DW'(1) : '1;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [AW-1:0] addr_i,
  output dec_t          dec_o
);
  logic [AW-1:0] word;
  assign word = {addr_i[AW-1:2], 2'b00};

  always_comb begin
    dec_o     = '0;
    dec_o.cls = ACC_NONE;
    unique case (word)
      OFF_SCRATCH: begin dec_o.cls = ACC_RW; dec_o.is_slot = 1'b1; dec_o.slot = SLOT_W'(SL_SCRATCH); end
      OFF_LOCK:    begin dec_o.cls = ACC_WO; dec_o.is_lock = 1'b1; end
      OFF_UNLOCK:  begin dec_o.cls = ACC_WO; dec_o.is_unlock = 1'b1; end
      OFF_STATUS:  begin dec_o.cls = ACC_RO; dec_o.is_sta = 1'b1; end
      OFF_PLL0:    begin dec_o.cls = ACC_RW; dec_o.is_slot = 1'b1; dec_o.slot = SLOT_W'(SL_PLL0); end
      OFF_PLL1:    begin dec_o.cls = ACC_RW; dec_o.is_slot = 1'b1; dec_o.slot = SLOT_W'(SL_PLL1); end
      OFF_PLL2:    begin dec_o.cls = ACC_RW; dec_o.is_slot = 1'b1; dec_o.slot = SLOT_W'(SL_PLL2); end
      OFF_PLLSTA:  begin dec_o.cls = ACC_RO; dec_o.is_slot = 1'b1; dec_o.slot = SLOT_W'(SL_PLLSTA); end
      OFF_UARTCK:  begin dec_o.cls = ACC_RW; dec_o.is_slot = 1'b1; dec_o.slot = SLOT_W'(SL_UARTCK); end
      OFF_SRST:    begin dec_o.cls = ACC_RW; dec_o.is_slot = 1'b1; dec_o.slot = SLOT_W'(SL_SRST); end
      OFF_BOOT:    begin dec_o.cls = ACC_RO; dec_o.is_slot = 1'b1; dec_o.slot = SLOT_W'(SL_BOOT); end
      OFF_ID:      begin dec_o.cls = ACC_RO; dec_o.is_slot = 1'b1; dec_o.slot = SLOT_W'(SL_ID); end
      OFF_CAL:     begin dec_o.cls = ACC_WO; dec_o.is_slot = 1'b1; dec_o.slot = SLOT_W'(SL_CAL); end
      OFF_REFR:    begin dec_o.cls = ACC_WO; dec_o.is_slot = 1'b1; dec_o.slot = SLOT_W'(SL_REFR); end
      default: ;
    endcase
  end
endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock #(
  parameter int                KEY_W      = 16,
  parameter logic [KEY_W-1:0]  LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0]  UNLOCK_KEY = 16'hDF0D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             is_lock_i,
  input  logic             is_unlock_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             locked_o
);
  logic set_lock, clr_lock;
  assign set_lock = wr_i && is_lock_i   && (key_i == LOCK_KEY);
  assign clr_lock = wr_i && is_unlock_i && (key_i == UNLOCK_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       locked_o <= 1'b1;
    else if (set_lock) locked_o <= 1'b1;
    else if (clr_lock) locked_o <= 1'b0;
  end

  // R2
  lock_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && is_lock_i && key_i == LOCK_KEY) |=> locked_o);

  // R3
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (is_lock_i || is_unlock_i) && key_i != LOCK_KEY && key_i != UNLOCK_KEY)
      |=> $stable(locked_o));
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [DW-1:0] ID_VALUE = 32'h1A5C_0001
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SLOT_W-1:0]          slot_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [NSLOT-1:0][DW-1:0]   regs_o
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        regs_o[g] <= slot_rst(g, ID_VALUE);
      else if (we_i && slot_i == SLOT_W'(g))
        regs_o[g] <= wdata_i & slot_mask(g);
    end
  end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter logic [KEY_W-1:0] LOCK_KEY   = 16'h767B,
  parameter logic [KEY_W-1:0] UNLOCK_KEY = 16'hDF0D,
  parameter logic [DW-1:0]    ID_VALUE   = 32'h1A5C_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          err_o,
  output logic          srst_o
);
  dec_t                    dec;
  logic                    locked;
  logic [NSLOT-1:0][DW-1:0] regs;
  logic                    wr_ok, rd_ok, store_we, err_d, srst_d;
  logic [DW-1:0]           rdata_d;

  sysctl_decode i_decode (.addr_i(addr_i), .dec_o(dec));

  sysctl_lock #(.KEY_W(KEY_W), .LOCK_KEY(LOCK_KEY), .UNLOCK_KEY(UNLOCK_KEY)) i_lock (
    .clk_i, .rst_ni, .wr_i,
    .is_lock_i(dec.is_lock), .is_unlock_i(dec.is_unlock),
    .key_i(wdata_i[KEY_W-1:0]), .locked_o(locked)
  );

  assign wr_ok    = (dec.cls == ACC_WO) || (dec.cls == ACC_RW);
  assign rd_ok    = (dec.cls == ACC_RO) || (dec.cls == ACC_RW);
  assign store_we = wr_i && wr_ok && dec.is_slot && !locked;
  assign err_d    = (rd_i && !rd_ok) || (wr_i && !wr_ok);
  assign srst_d   = store_we && (dec.slot == SLOT_W'(SL_SRST)) && wdata_i[0];

  sysctl_regfile #(.ID_VALUE(ID_VALUE)) i_regfile (
    .clk_i, .rst_ni, .we_i(store_we), .slot_i(dec.slot), .wdata_i, .regs_o(regs)
  );

  always_comb begin
    rdata_d = '0;
    if (dec.is_sta)       rdata_d = DW'(locked);
    else if (dec.is_slot) rdata_d = regs[dec.slot];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
      srst_o  <= 1'b0;
    end else begin
      if (rd_i) rdata_o <= rdata_d;
      err_o  <= err_d;
      srst_o <= srst_d;
    end
  end

  // R4
  locked_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && wr_i) |=> $stable(regs));

  // R5
  err_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(rd_i || wr_i));

  // R9
  srst_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |-> ($past(wr_i) && !$past(locked)));

  // R10
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rd_i) |-> $stable(rdata_o));
endmodule

// File: tb/test_sysctl_bank.sv
module test_sysctl_bank;
  import sysctl_pkg::*;

  localparam logic [DW-1:0] ID = 32'h1A5C_0001;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [DW-1:0] rdata;
  logic          err, srst;
  int            total = 0, bad = 0;
  bit            done = 1'b0;

  always #4 clk = ~clk;

  sysctl_bank #(.ID_VALUE(ID)) i_sysctl_bank (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .err_o(err), .srst_o(srst)
  );

  typedef struct packed {
    logic          w;
    logic [11:0]   a;
    logic [31:0]   d;
    logic [31:0]   exp;
    logic          e;
    logic          s;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h00C, 32'h0, 32'h1,          1'b0, 1'b0, 4'd1},  // R1 starts locked
    '{1'b0, 12'h100, 32'h0, 32'h0001_A008,  1'b0, 1'b0, 4'd1},  // R1
    '{1'b0, 12'h108, 32'h0, 32'h0001_A008,  1'b0, 1'b0, 4'd1},  // R1
    '{1'b0, 12'h10C, 32'h0, 32'h0000_003F,  1'b0, 1'b0, 4'd1},  // R1
    '{1'b0, 12'h154, 32'h0, 32'h0000_3F03,  1'b0, 1'b0, 4'd1},  // R1
    '{1'b1, 12'h100, 32'h1234, 32'h0,       1'b0, 1'b0, 4'd4},  // R4 locked write
    '{1'b0, 12'h100, 32'h0, 32'h0001_A008,  1'b0, 1'b0, 4'd4},  // R4
    '{1'b1, 12'h008, 32'h1111, 32'h0,       1'b0, 1'b0, 4'd3},  // R3 bad key
    '{1'b0, 12'h00C, 32'h0, 32'h1,          1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 12'h008, 32'hABCD_DF0D, 32'h0,  1'b0, 1'b0, 4'd3},  // R3 good key
    '{1'b0, 12'h00C, 32'h0, 32'h0,          1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 12'h100, 32'h1234, 32'h0,       1'b0, 1'b0, 4'd4},  // R4 unlocked
    '{1'b0, 12'h100, 32'h0, 32'h1234,       1'b0, 1'b0, 4'd4},  // R4
    '{1'b1, 12'h000, 32'hFFFF_FFFF, 32'h0,  1'b0, 1'b0, 4'd8},  // R8
    '{1'b0, 12'h000, 32'h0, 32'h1,          1'b0, 1'b0, 4'd8},  // R8
    '{1'b1, 12'h10C, 32'h0, 32'h0,          1'b1, 1'b0, 4'd6},  // R6 write RO
    '{1'b0, 12'h10C, 32'h0, 32'h0000_003F,  1'b0, 1'b0, 4'd6},  // R6
    '{1'b1, 12'h020, 32'hDEAD, 32'h0,       1'b1, 1'b0, 4'd6},  // R6 unmapped
    '{1'b0, 12'h020, 32'h0, 32'h0,          1'b1, 1'b0, 4'd5},  // R5 unmapped read
    '{1'b0, 12'h004, 32'h0, 32'h0,          1'b1, 1'b0, 4'd7},  // R7
    '{1'b1, 12'h60C, 32'h55, 32'h0,         1'b0, 1'b0, 4'd7},  // R7
    '{1'b0, 12'h60C, 32'h0, 32'h55,         1'b1, 1'b0, 4'd7},  // R7
    '{1'b0, 12'h157, 32'h0, 32'h0000_3F03,  1'b0, 1'b0, 4'd10}, // R10 low bits
    '{1'b1, 12'h200, 32'h2, 32'h0,          1'b0, 1'b0, 4'd9},  // R9 bit0 clear
    '{1'b0, 12'h200, 32'h0, 32'h2,          1'b0, 1'b0, 4'd9},  // R9
    '{1'b1, 12'h200, 32'h1, 32'h0,          1'b0, 1'b1, 4'd9},  // R9 request
    '{1'b0, 12'h200, 32'h0, 32'h1,          1'b0, 1'b0, 4'd9},  // R9
    '{1'b1, 12'h004, 32'h767A, 32'h0,       1'b0, 1'b0, 4'd2},  // R2 bad key
    '{1'b0, 12'h00C, 32'h0, 32'h0,          1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 12'h004, 32'h0000_767B, 32'h0,  1'b0, 1'b0, 4'd2},  // R2 good key
    '{1'b0, 12'h00C, 32'h0, 32'h1,          1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, 12'h200, 32'h1, 32'h0,          1'b0, 1'b0, 4'd9},  // R9 locked
    '{1'b0, 12'h25C, 32'h0, 32'h1,          1'b0, 1'b0, 4'd1},  // R1
    '{1'b0, 12'h530, 32'h0, ID,             1'b0, 1'b0, 4'd1},  // R1
    '{1'b1, 12'h25C, 32'h7, 32'h0,          1'b1, 1'b0, 4'd5}   // R5 write RO
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = w; rd = !w; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state of outputs
    check(rdata, 32'h0, 1, "rdata after reset");
    check(32'(err), 32'h0, 1, "err after reset");
    check(32'(srst), 32'h0, 1, "srst after reset");
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op(VEC[i].w, VEC[i].a, VEC[i].d);
      if (!VEC[i].w) check(rdata, VEC[i].exp, int'(VEC[i].req), $sformatf("rdata vec %0d", i));
      check(32'(err), 32'(VEC[i].e), int'(VEC[i].req), $sformatf("err vec %0d", i));
      check(32'(srst), 32'(VEC[i].s), int'(VEC[i].req), $sformatf("srst vec %0d", i));
    end

    // R10 rdata holds, pulses drop, when no strobe
    op(1'b0, 12'h020, 32'h0);
    @(negedge clk);
    check(rdata, 32'h0, 10, "rdata hold after read");
    check(32'(err), 32'h0, 5, "err one cycle only");

    // R3 unlock, R9 pulse lasts one cycle
    op(1'b1, 12'h008, 32'h0000_DF0D);
    op(1'b1, 12'h200, 32'h1);
    @(negedge clk);
    check(32'(srst), 32'h0, 9, "srst one cycle only");

    // R1 reset relocks and restores
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    op(1'b0, 12'h00C, 32'h0);
    check(rdata, 32'h1, 1, "locked after second reset");
    op(1'b0, 12'h100, 32'h0);
    check(rdata, 32'h0001_A008, 1, "pll ctrl after second reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule